// File: doc/BRIEF.md
# Frame Subframe Sync Detector

This block sits after word recovery on a serial flight-data receive path. It sees one 12-bit word per `word_vld` strobe and looks for the four subframe sync marks, octal 1107, 2670, 5107 and 6670, which must occur in that cyclic order. Each mark must arrive exactly one subframe after the previous one. One subframe is `SF_LEN` words, and spacing is measured by counting valid words. Once the block has seen a properly spaced run of marks, it declares lock and forwards every received word to a downstream receive buffer through a one-cycle strobe. It also reports which subframe is current. Until it has lock, it forwards nothing.

The block is a three-state machine. HUNT waits for a first candidate mark. ACQUIRE counts properly spaced marks in order. LOCKED forwards words and checks each expected mark position. These are the transitions:

- HUNT→ACQUIRE (candidate seen). In normal mode the candidate must be 1107; in software-sync mode it may be any mark.
- ACQUIRE→ACQUIRE, in two ways. A correct mark in the correct position advances the count. A misplaced or out-of-order mark that is itself a candidate restarts the search on that word.
- ACQUIRE→HUNT (bad word in a mark position, or a misplaced non-candidate mark).
- ACQUIRE→LOCKED (lock mark). This is the fifth mark in normal mode and the third in software-sync mode.
- LOCKED→LOCKED (mark matched, or ordinary data).
- LOCKED→ACQUIRE or LOCKED→HUNT (lock lost). The word in a mark position is not the expected mark. It is not forwarded, and it is reused as a new candidate when it qualifies.

A pass-through mode forwards every word and overrides all sync logic, holding the machine in HUNT. A synchronous software reset returns the machine to HUNT.

Top module: `sf_sync_tracker`

## Requirements
- R1: Marks are decoded as 12'o1107, 12'o2670, 12'o5107 and 12'o6670, with subframe codes 0, 1, 2 and 3. After code 3 the next expected mark is code 0. A mark is in position when exactly `SF_LEN` valid words separate it from the previous accepted mark, counting the mark itself and ignoring cycles with `word_vld` low.
- R2: In normal mode, `in_sync` rises in the cycle after the fifth mark of a run. The run starts with 1107, and all five marks are in order and in position.
- R3: In software-sync mode, `in_sync` rises in the cycle after the third in-order, in-position mark of a run that may start with any mark.
- R4: While not locked and not in pass-through mode, `fwd_strobe` stays low.
- R5: `sf_idx` takes the code of each accepted mark in the cycle after it, including the lock mark. It holds between marks.
- R6: While locked, every valid word gives `fwd_strobe` high for one cycle in the following cycle, with `fwd_word` equal to that word.
- R7: If a locked word in mark position is not the expected mark, `in_sync` falls in the next cycle and that word is not forwarded.
- R8: A mark in the wrong position or out of order during acquisition, or at a lost-lock position, restarts acquisition with that word as the first mark when it qualifies as a candidate, and otherwise returns to hunting.
- R9: With `passthru_mode` high, every valid word is forwarded in the next cycle and `in_sync` is low.
- R10: `soft_rst` high gives `in_sync` low, `sf_idx` equal to 0 and no forward in the next cycle, and acquisition then starts afresh.
- R11: After `rst_n` is released, `in_sync` is 0, `sf_idx` is 0 and `fwd_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of all sync state |
| swsync_mode | input | 1 | Relaxed lock: three marks, any start |
| passthru_mode | input | 1 | Forward every word, sync logic held idle |
| word_vld | input | 1 | Word strobe |
| word_in | input | 12 | Received word |
| in_sync | output | 1 | Frame lock held |
| sf_idx | output | 2 | Code of the last accepted mark |
| fwd_strobe | output | 1 | Forward strobe to the receive buffer |
| fwd_word | output | 12 | Forwarded word |

## Verification
The bench builds the block with `SF_LEN` = 8, so a full normal-mode lock takes only 33 words. This keeps thousands of cycles of lock acquisition, lock loss and restart within a short run. With a short subframe, random idle cycles, corrupted or swapped marks, mode changes and soft resets all fall close to mark positions. That brings the wrong-spacing restart, the lost-lock candidate reuse and the counting of valid words only (not cycles) into regular reach.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int WORD_W = 12;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_LOCKED  = 2'd2
    } sfs_state_e;

    function automatic logic [WORD_W-1:0] mark_value(input logic [1:0] code);
        unique case (code)
            2'd0:    mark_value = 12'o1107;
            2'd1:    mark_value = 12'o2670;
            2'd2:    mark_value = 12'o5107;
            default: mark_value = 12'o6670;
        endcase
    endfunction
endpackage

// File: rtl/sfs_mark_decode.sv
module sfs_mark_decode
    import sfs_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_mark,
    output logic [1:0]        code
);
    localparam int N_MARKS = 4;
    logic [N_MARKS-1:0] hit;

    for (genvar g = 0; g < N_MARKS; g++) begin : g_cmp
        assign hit[g] = (word == mark_value(2'(g)));
    end

    assign is_mark = |hit;

    always_comb begin
        code = 2'd0;
        for (int i = 0; i < N_MARKS; i++) begin
            if (hit[i]) code = 2'(i);
        end
    end
endmodule

// File: rtl/sfs_space_counter.sv
module sfs_space_counter #(
    parameter int SF_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic vld,
    output logic at_pos
);
    localparam int CW   = $clog2(SF_LEN);
    localparam int LAST = SF_LEN - 1;

    logic [CW-1:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (clr) begin
            wcnt <= '0;
        end else if (vld && (wcnt != CW'(LAST))) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    assign at_pos = vld && (wcnt == CW'(LAST));
endmodule

// File: rtl/sfs_fsm.sv
module sfs_fsm
    import sfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              swsync_mode,
    input  logic              passthru_mode,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              is_mark,
    input  logic [1:0]        code,
    input  logic              at_pos,
    output logic              cnt_clr,
    output logic              in_sync,
    output logic [1:0]        sf_idx,
    output logic              fwd_strobe,
    output logic [WORD_W-1:0] fwd_word
);
    sfs_state_e state, nxt_state;
    logic [1:0] exp_q, nxt_exp;
    logic [2:0] seen_q, nxt_seen;
    logic [1:0] nxt_idx;
    logic       take;
    logic       cand;
    logic       match;
    logic [2:0] need;

    assign cand  = is_mark && (swsync_mode || code == 2'd0);
    assign match = is_mark && (code == exp_q);
    assign need  = swsync_mode ? 3'd2 : 3'd4;

    always_comb begin
        nxt_state = state;
        nxt_exp   = exp_q;
        nxt_seen  = seen_q;
        nxt_idx   = sf_idx;
        take      = 1'b0;
        cnt_clr   = 1'b0;
        if (soft_rst) begin
            nxt_state = ST_HUNT;
            nxt_exp   = 2'd0;
            nxt_seen  = 3'd0;
            nxt_idx   = 2'd0;
            cnt_clr   = 1'b1;
        end else if (passthru_mode) begin
            nxt_state = ST_HUNT;
            nxt_seen  = 3'd0;
            cnt_clr   = 1'b1;
            take      = word_vld;
        end else if (word_vld) begin
            unique case (state)
                ST_HUNT: begin
                    if (cand) begin
                        nxt_state = ST_ACQUIRE;
                        nxt_exp   = code + 2'd1;
                        nxt_seen  = 3'd1;
                        cnt_clr   = 1'b1;
                    end
                end
                ST_ACQUIRE: begin
                    if (at_pos && match) begin
                        nxt_exp = exp_q + 2'd1;
                        cnt_clr = 1'b1;
                        if (seen_q >= need) begin
                            nxt_state = ST_LOCKED;
                            nxt_idx   = exp_q;
                            take      = 1'b1;
                        end else begin
                            nxt_seen = seen_q + 3'd1;
                        end
                    end else if (at_pos || is_mark) begin
                        cnt_clr   = 1'b1;
                        nxt_state = cand ? ST_ACQUIRE : ST_HUNT;
                        nxt_exp   = code + 2'd1;
                        nxt_seen  = cand ? 3'd1 : 3'd0;
                    end
                end
                ST_LOCKED: begin
                    take = 1'b1;
                    if (at_pos) begin
                        cnt_clr = 1'b1;
                        if (match) begin
                            nxt_idx = exp_q;
                            nxt_exp = exp_q + 2'd1;
                        end else begin
                            take      = 1'b0;
                            nxt_state = cand ? ST_ACQUIRE : ST_HUNT;
                            nxt_exp   = code + 2'd1;
                            nxt_seen  = cand ? 3'd1 : 3'd0;
                        end
                    end
                end
                default: nxt_state = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HUNT;
            exp_q  <= 2'd0;
            seen_q <= 3'd0;
        end else begin
            state  <= nxt_state;
            exp_q  <= nxt_exp;
            seen_q <= nxt_seen;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sync    <= 1'b0;
            sf_idx     <= 2'd0;
            fwd_strobe <= 1'b0;
            fwd_word   <= '0;
        end else begin
            in_sync    <= (nxt_state == ST_LOCKED);
            sf_idx     <= nxt_idx;
            fwd_strobe <= take;
            if (take) fwd_word <= word_in;
        end
    end
endmodule

// File: rtl/sf_sync_tracker.sv
module sf_sync_tracker #(
    parameter int SF_LEN = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        swsync_mode,
    input  logic        passthru_mode,
    input  logic        word_vld,
    input  logic [11:0] word_in,
    output logic        in_sync,
    output logic [1:0]  sf_idx,
    output logic        fwd_strobe,
    output logic [11:0] fwd_word
);
    logic       is_mark;
    logic [1:0] code;
    logic       at_pos;
    logic       cnt_clr;

    sfs_mark_decode u_dec (
        .word    (word_in),
        .is_mark (is_mark),
        .code    (code)
    );

    sfs_space_counter #(.SF_LEN(SF_LEN)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .vld    (word_vld),
        .at_pos (at_pos)
    );

    sfs_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .swsync_mode   (swsync_mode),
        .passthru_mode (passthru_mode),
        .word_vld      (word_vld),
        .word_in       (word_in),
        .is_mark       (is_mark),
        .code          (code),
        .at_pos        (at_pos),
        .cnt_clr       (cnt_clr),
        .in_sync       (in_sync),
        .sf_idx        (sf_idx),
        .fwd_strobe    (fwd_strobe),
        .fwd_word      (fwd_word)
    );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        passthru_mode,
    input logic        word_vld,
    input logic [11:0] word_in,
    input logic        in_sync,
    input logic [1:0]  sf_idx,
    input logic        fwd_strobe,
    input logic [11:0] fwd_word
);
    p_fwd_needs_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_strobe |-> (in_sync || $past(passthru_mode)));

    p_fwd_from_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_strobe |-> $past(word_vld));

    p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!in_sync && !fwd_strobe && sf_idx == 2'd0));

    p_passthru_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (passthru_mode && word_vld && !soft_rst) |=>
            (fwd_strobe && !in_sync && fwd_word == $past(word_in)));

    p_lock_on_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> fwd_strobe);

    p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && $past(in_sync) && !fwd_strobe) |-> $stable(sf_idx));
endmodule

bind sf_sync_tracker sfs_checker u_sfs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .passthru_mode (passthru_mode),
    .word_vld      (word_vld),
    .word_in       (word_in),
    .in_sync       (in_sync),
    .sf_idx        (sf_idx),
    .fwd_strobe    (fwd_strobe),
    .fwd_word      (fwd_word)
);

// File: tb/sf_sync_tracker_bench.sv
`timescale 1ns/1ps
module sf_sync_tracker_bench;
    localparam int L = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        swsync_mode = 1'b0;
    logic        passthru_mode = 1'b0;
    logic        word_vld = 1'b0;
    logic [11:0] word_in = '0;
    logic        in_sync;
    logic [1:0]  sf_idx;
    logic        fwd_strobe;
    logic [11:0] fwd_word;

    int n_vec = 0;
    int n_bad = 0;

    // reference model state: 0 hunt, 1 acquiring, 2 locked
    int          m_st = 0;
    int          m_pos = 0;
    int          m_seen = 0;
    int          m_next = 0;
    logic        e_sync = 1'b0;
    logic [1:0]  e_idx = 2'd0;
    logic        e_fwd = 1'b0;
    logic [11:0] e_word = '0;

    always #5 clk = ~clk;

    sf_sync_tracker #(.SF_LEN(L)) u_sf_sync_tracker (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .swsync_mode(swsync_mode), .passthru_mode(passthru_mode),
        .word_vld(word_vld), .word_in(word_in),
        .in_sync(in_sync), .sf_idx(sf_idx),
        .fwd_strobe(fwd_strobe), .fwd_word(fwd_word)
    );

    // R1: mark table
    function automatic logic [11:0] mk(input int c);
        case (c % 4)
            0: return 12'o1107;
            1: return 12'o2670;
            2: return 12'o5107;
            default: return 12'o6670;
        endcase
    endfunction

    function automatic int mk_code(input logic [11:0] w);
        for (int c = 0; c < 4; c++) if (w == mk(c)) return c;
        return -1;
    endfunction

    task automatic start_candidate(input int c);
        if (c >= 0 && (swsync_mode || c == 0)) begin
            m_st = 1; m_seen = 1; m_next = (c + 1) % 4;
        end else begin
            m_st = 0; m_seen = 0;
        end
        m_pos = 0;
    endtask

    task automatic model_step();
        int c;
        bit spot;
        e_fwd = 1'b0;
        c = mk_code(word_in);
        if (soft_rst) begin
            m_st = 0; m_seen = 0; m_pos = 0; e_idx = 2'd0;
        end else if (passthru_mode) begin
            m_st = 0; m_seen = 0; m_pos = 0;
            if (word_vld) begin e_fwd = 1'b1; e_word = word_in; end
        end else if (word_vld) begin
            spot = (m_pos == L - 1);
            if (m_pos < L - 1) m_pos++;
            if (m_st == 0) begin
                if (c >= 0) start_candidate(c);
            end else if (m_st == 1) begin
                if (spot && c == m_next) begin
                    m_pos = 0;
                    if (m_seen >= (swsync_mode ? 2 : 4)) begin
                        m_st = 2; e_idx = 2'(m_next);
                        e_fwd = 1'b1; e_word = word_in;
                    end else m_seen++;
                    m_next = (m_next + 1) % 4;
                end else if (spot || c >= 0) start_candidate(c);
            end else begin
                if (spot && c == m_next) begin
                    m_pos = 0; e_idx = 2'(m_next); m_next = (m_next + 1) % 4;
                    e_fwd = 1'b1; e_word = word_in;
                end else if (spot) start_candidate(c);
                else begin e_fwd = 1'b1; e_word = word_in; end
            end
        end
        e_sync = (m_st == 2);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one word per call: drive at negedge, compare at the next negedge
    task automatic cyc(input logic v, input logic [11:0] w);
        word_vld = v; word_in = w;
        model_step();
        @(negedge clk);
        chk(e_sync ? "R2" : "R7", "in_sync", int'(in_sync), int'(e_sync));
        chk("R4", "fwd_strobe", int'(fwd_strobe), int'(e_fwd));
        if (e_fwd) chk("R6", "fwd_word", int'(fwd_word), int'(e_word));
        chk("R5", "sf_idx", int'(sf_idx), int'(e_idx));
    endtask

    function automatic logic [11:0] rand_data();
        logic [11:0] w;
        do w = 12'($urandom); while (mk_code(w) >= 0);
        return w;
    endfunction

    // send n subframes starting at mark code c
    task automatic send_subframes(input int c, input int n);
        for (int s = 0; s < n; s++) begin
            cyc(1'b1, mk(c + s));
            for (int k = 1; k < L; k++) cyc(1'b1, rand_data());
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1717));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "in_sync", int'(in_sync), 0);
        chk("R11", "sf_idx", int'(sf_idx), 0);
        chk("R11", "fwd_strobe", int'(fwd_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: normal lock needs 1107 start, four marks, lock at fifth
        send_subframes(0, 4);
        chk("R2", "no lock before fifth mark", int'(in_sync), 0);
        cyc(1'b1, mk(0));
        chk("R2", "lock at fifth mark", int'(in_sync), 1);
        chk("R5", "idx at lock", int'(sf_idx), 0);
        for (int k = 1; k < L; k++) cyc(1'b1, rand_data());
        cyc(1'b0, '0);
        cyc(1'b1, mk(1));
        chk("R5", "idx after 2670", int'(sf_idx), 1);
        // R7: wrong word at mark position drops lock
        for (int k = 1; k < L; k++) cyc(1'b1, rand_data());
        cyc(1'b1, rand_data());
        chk("R7", "lock dropped", int'(in_sync), 0);
        chk("R7", "bad word not forwarded", int'(fwd_strobe), 0);

        // R3: software sync from 2670, lock at third mark
        swsync_mode = 1'b1;
        soft_rst = 1'b1; cyc(1'b0, '0); soft_rst = 1'b0;
        send_subframes(1, 2);
        cyc(1'b1, mk(3));
        chk("R3", "sw lock at third mark", int'(in_sync), 1);
        chk("R3", "idx 6670", int'(sf_idx), 3);

        // R10: soft reset clears lock
        soft_rst = 1'b1; cyc(1'b1, rand_data()); soft_rst = 1'b0;
        chk("R10", "in_sync cleared", int'(in_sync), 0);

        // R8: early mark restarts acquisition with that word
        cyc(1'b1, mk(0));
        cyc(1'b1, rand_data());
        cyc(1'b1, mk(2));
        for (int k = 1; k < L; k++) cyc(1'b1, rand_data());
        cyc(1'b1, mk(3));
        for (int k = 1; k < L; k++) cyc(1'b1, rand_data());
        cyc(1'b1, mk(0));
        chk("R8", "locked from restarted candidate", int'(in_sync), 1);

        // R9: pass-through forwards everything
        passthru_mode = 1'b1;
        cyc(1'b1, 12'h123);
        chk("R9", "pass-through forward", int'(fwd_strobe), 1);
        chk("R9", "pass-through in_sync low", int'(in_sync), 0);
        passthru_mode = 1'b0;
        swsync_mode = 1'b0;

        // random stream with corruptions, idles and mode changes
        begin
            int code = 0;
            for (int i = 0; i < 6000; i++) begin
                int r;
                r = int'($urandom_range(0, 999));
                soft_rst = (r < 3);
                if (r > 995) swsync_mode = ~swsync_mode;
                passthru_mode = (i % 1500) > 1470;
                if ($urandom_range(0, 9) < 2) begin
                    cyc(1'b0, rand_data());
                end else begin
                    logic [11:0] w;
                    r = int'($urandom_range(0, 99));
                    w = mk(code);
                    if (r < 4) w = rand_data();
                    else if (r < 8) w = mk(code + 2);
                    cyc(1'b1, w);
                    code++;
                    for (int k = 1; k < L; k++) begin
                        while ($urandom_range(0, 9) == 0) cyc(1'b0, rand_data());
                        if ($urandom_range(0, 199) == 0) cyc(1'b1, mk(0));
                        else cyc(1'b1, rand_data());
                    end
                end
            end
        end
        soft_rst = 1'b0;
        passthru_mode = 1'b0;
        cyc(1'b0, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule